// File: doc/BRIEF.md
# Multi-Stream TDM Slot Transmitter

This block places up to six sensor sample streams onto one shared TDM serial data line. The line is divided into 8-bit transmit slots. The streams are speaker voltage sense, speaker current sense, decimated PDM, battery voltage, die temperature and limiter gain. Each stream has a 6-bit index that names the slot holding its most significant byte, and an enable of its own. Several devices can share one line. Each device claims only its own slots and leaves every other bit either released (high impedance) or driven low.

The block runs on a fast system clock. The bit clock and the frame sync arrive as synchronous level inputs, and the block finds their edges itself. The frame sync is sampled on the rising bit-clock edge. A frame starts when the sampled sync moves in the direction that `frame_pol` selects. Each stream's parallel sample is captured on that edge and held for the whole frame. The length of the frame just ended sets the boundary for the next frame, and no bit is sent at or past that boundary. The pair `sd_out`/`sd_oe` models a three-state pad.

Top module: `tdm_mstream_tx`

## Requirements
- R1: Bit p of a frame (p = 0 at the frame-start edge) belongs to slot (p - tx_offset) / 8, at bit (p - tx_offset) mod 8 of that slot. Slots are sent most significant bit first. Bits with p < tx_offset belong to no slot.
- R2: Stream 0 (voltage, `vsns_in`), stream 1 (current, `isns_in`) and stream 2 (PDM, `pdm_in`) are 16 bits wide. Each fills its indexed slot with its upper byte and the following slot with its lower byte.
- R3: Stream 3 (battery, `vbat_in`, 12 bits): with `vbat_wide`=0 only bits 11..4 are sent, in one slot. With `vbat_wide`=1 the word {vbat_in, 4'b0000} is sent across two slots, upper byte first.
- R4: Stream 4 (temperature) and stream 5 (gain) are 8 bits wide and fill one slot each.
- R5: Stream i sends only when `stream_en[i]` is 1. Its start slot is `slot_idx[6*i+5:6*i]`, with a range of 0 to 63.
- R6: `tx_offset` (0 to 7) shifts slot 0 by that many bit-clock cycles after the frame start.
- R7: With `tx_on_fall`=1, the outputs for bit p change only on the falling bit-clock edge of cycle p. With `tx_on_fall`=0 they change on the rising edge that begins cycle p. They hold between those edges.
- R8: A bit that no enabled stream owns gives `sd_oe`=0 when `fill_hiz`=1, and `sd_oe`=1 with `sd_out`=0 when `fill_hiz`=0. Whenever `sd_oe` is 0, `sd_out` is 0. Reset releases the line.
- R9: A bit at position p is sent only if p is below the length, in bit-clock cycles, of the previous complete frame. Until one complete frame has been measured after reset, nothing is sent.
- R10: When enabled streams claim the same bit, the lowest stream number wins: voltage, then current, PDM, battery, temperature, gain.
- R11: Sample inputs are captured at the frame-start edge. Changes to them during the frame have no effect until the next frame.
- R12: With `frame_pol`=1 a frame starts on a high-to-low change of the sampled sync. With `frame_pol`=0 it starts on a low-to-high change. A change in the other direction does not restart the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk | input | 1 | Bit clock level, synchronous to clk |
| fsync | input | 1 | Frame sync level, synchronous to clk |
| frame_pol | input | 1 | 1: frame starts on sync falling; 0: on sync rising |
| tx_on_fall | input | 1 | 1: outputs change on the bit-clock falling edge; 0: on the rising edge |
| tx_offset | input | 3 | Bit-clock cycles from frame start to slot 0 |
| fill_hiz | input | 1 | Unowned bits: 1 released, 0 driven low |
| stream_en | input | 6 | Per-stream enable, bit i for stream i |
| slot_idx | input | 36 | Six 6-bit start-slot indices, stream i at bits 6i+5..6i |
| vbat_wide | input | 1 | Battery stream: 0 one slot, 1 two slots |
| vsns_in | input | 16 | Voltage sense sample |
| isns_in | input | 16 | Current sense sample |
| pdm_in | input | 16 | Decimated PDM sample |
| vbat_in | input | 12 | Battery voltage sample |
| temp_in | input | 8 | Die temperature sample |
| gain_in | input | 8 | Limiter gain sample |
| sd_out | output | 1 | Serial data bit |
| sd_oe | output | 1 | Drive enable for sd_out (0 = high impedance) |

## Verification
The hardest case to reach is a frame whose claimed bits run past its boundary while streams overlap. In that case truncation, priority and the fill level all act in the same frame. The boundary also comes from the previous frame, not the current one. The stimulus therefore changes the frame length from frame to frame, so that the measured boundary is sometimes shorter than the frame now being sent. It places random start slots far enough out to cross the boundary, so overlaps between streams occur naturally. It also changes the sample inputs in the middle of each frame, to show that the captured values are the ones sent.

// File: rtl/tdm_mstx_pkg.sv
package tdm_mstx_pkg;
  localparam int NSTR   = 6;   // number of sample streams
  localparam int IDX_W  = 6;   // start-slot index width
  localparam int OFF_W  = 3;   // slot-0 offset width
  localparam int WORD_W = 16;  // widest stream word
  localparam int SLOT_B = 8;   // bits per transmit slot

  typedef enum logic [2:0] {
    STR_VSNS = 3'd0,
    STR_ISNS = 3'd1,
    STR_PDM  = 3'd2,
    STR_VBAT = 3'd3,
    STR_TEMP = 3'd4,
    STR_GAIN = 3'd5
  } stream_e;

  // Does a stream that starts at slot 'first' cover slot 'slot'?
  function automatic logic owns_slot(int first, logic two, int slot);
    return (slot == first) || (two && (slot == first + 1));
  endfunction

  // Bit b (0 = MSB) of the upper (second=0) or lower (second=1) byte.
  function automatic logic word_bit(logic [WORD_W-1:0] w, logic second, logic [2:0] b);
    return w[{~second, ~b}];
  endfunction
endpackage

// File: rtl/tdm_mstx_frame.sv
module tdm_mstx_frame #(
  parameter int POS_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bclk,
  input  logic             fsync,
  input  logic             frame_pol,
  output logic             rise_evt,
  output logic             fall_evt,
  output logic             start_evt,
  output logic [POS_W-1:0] pos_q,
  output logic [POS_W-1:0] pos_d,
  output logic [POS_W:0]   len_q,
  output logic [POS_W:0]   len_d
);
  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic bclk_q, fs_q, seen_q;

  always_comb begin
    rise_evt  = bclk & ~bclk_q;
    fall_evt  = ~bclk & bclk_q;
    start_evt = rise_evt & (frame_pol ? (fs_q & ~fsync) : (~fs_q & fsync));
    pos_d = pos_q;
    if (start_evt)                         pos_d = '0;
    else if (rise_evt && pos_q != POS_MAX) pos_d = pos_q + 1'b1;
    len_d = len_q;
    if (start_evt && seen_q) len_d = {1'b0, pos_q} + (POS_W+1)'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q <= 1'b0;
      fs_q   <= 1'b0;
      seen_q <= 1'b0;
      pos_q  <= '0;
      len_q  <= '0;
    end else begin
      bclk_q <= bclk;
      if (rise_evt)  fs_q   <= fsync;
      if (start_evt) seen_q <= 1'b1;
      pos_q <= pos_d;
      len_q <= len_d;
    end
  end

  // R12: a detected frame start always restarts the bit position
  assert_frame_restart_R12: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (pos_q == '0));

  // R9: the boundary only changes at a frame start
  assert_len_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !start_evt |=> $stable(len_q));
endmodule

// File: rtl/tdm_mstx_slotmap.sv
module tdm_mstx_slotmap
  import tdm_mstx_pkg::*;
#(
  parameter int POS_W = 10
) (
  input  logic [POS_W-1:0]             bit_pos,
  input  logic [OFF_W-1:0]             offset,
  input  logic [NSTR-1:0]              en,
  input  logic [NSTR*IDX_W-1:0]        slot_idx,
  input  logic [NSTR-1:0][WORD_W-1:0]  words,
  input  logic [NSTR-1:0]              two_slot,
  input  logic [POS_W:0]               frame_len,
  output logic                         owned,
  output logic                         bit_val,
  output logic                         past_end
);
  localparam int SLOT_NUM_W = POS_W - 3;

  logic                  lead_in;
  logic [POS_W-1:0]      rel;
  logic [SLOT_NUM_W-1:0] slot_num;
  logic [2:0]            bsel;
  logic [NSTR-1:0]       hit, hit_bit;
  logic                  any_hit, win_bit;

  assign lead_in  = bit_pos < POS_W'(offset);
  assign rel      = bit_pos - POS_W'(offset);
  assign slot_num = rel[POS_W-1:3];
  assign bsel     = rel[2:0];

  for (genvar i = 0; i < NSTR; i++) begin : g_str
    logic [IDX_W-1:0] first;
    logic             second;
    assign first      = slot_idx[i*IDX_W +: IDX_W];
    assign second     = int'(slot_num) != int'(first);
    assign hit[i]     = en[i] & ~lead_in & owns_slot(int'(first), two_slot[i], int'(slot_num));
    assign hit_bit[i] = word_bit(words[i], second, bsel);
  end

  // lowest stream number wins (R10)
  always_comb begin
    any_hit = 1'b0;
    win_bit = 1'b0;
    for (int i = NSTR-1; i >= 0; i--) begin
      if (hit[i]) begin
        any_hit = 1'b1;
        win_bit = hit_bit[i];
      end
    end
  end

  assign past_end = {1'b0, bit_pos} >= frame_len;
  assign owned    = any_hit & ~past_end;
  assign bit_val  = win_bit;
endmodule

// File: rtl/tdm_mstream_tx.sv
module tdm_mstream_tx
  import tdm_mstx_pkg::*;
#(
  parameter int POS_W = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bclk,
  input  logic        fsync,
  input  logic        frame_pol,
  input  logic        tx_on_fall,
  input  logic [2:0]  tx_offset,
  input  logic        fill_hiz,
  input  logic [5:0]  stream_en,
  input  logic [35:0] slot_idx,
  input  logic        vbat_wide,
  input  logic [15:0] vsns_in,
  input  logic [15:0] isns_in,
  input  logic [15:0] pdm_in,
  input  logic [11:0] vbat_in,
  input  logic [7:0]  temp_in,
  input  logic [7:0]  gain_in,
  output logic        sd_out,
  output logic        sd_oe
);
  logic             rise_evt, fall_evt, start_evt, tx_evt;
  logic [POS_W-1:0] pos_q, pos_d, tx_pos;
  logic [POS_W:0]   len_q, len_d, tx_len;
  logic             map_owned, map_bit, map_past_end;

  logic [15:0] lat_vsns, lat_isns, lat_pdm, cur_vsns, cur_isns, cur_pdm;
  logic [11:0] lat_vbat, cur_vbat;
  logic [7:0]  lat_temp, lat_gain, cur_temp, cur_gain;
  logic [NSTR-1:0][WORD_W-1:0] words;
  logic [NSTR-1:0]             two_slot;

  tdm_mstx_frame #(.POS_W(POS_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync), .frame_pol(frame_pol),
    .rise_evt(rise_evt), .fall_evt(fall_evt), .start_evt(start_evt),
    .pos_q(pos_q), .pos_d(pos_d), .len_q(len_q), .len_d(len_d)
  );

  // sample capture at frame start (R11)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_vsns <= '0; lat_isns <= '0; lat_pdm  <= '0;
      lat_vbat <= '0; lat_temp <= '0; lat_gain <= '0;
    end else if (start_evt) begin
      lat_vsns <= vsns_in; lat_isns <= isns_in; lat_pdm  <= pdm_in;
      lat_vbat <= vbat_in; lat_temp <= temp_in; lat_gain <= gain_in;
    end
  end

  always_comb begin
    cur_vsns = start_evt ? vsns_in : lat_vsns;
    cur_isns = start_evt ? isns_in : lat_isns;
    cur_pdm  = start_evt ? pdm_in  : lat_pdm;
    cur_vbat = start_evt ? vbat_in : lat_vbat;
    cur_temp = start_evt ? temp_in : lat_temp;
    cur_gain = start_evt ? gain_in : lat_gain;
    words[STR_VSNS] = cur_vsns;
    words[STR_ISNS] = cur_isns;
    words[STR_PDM]  = cur_pdm;
    words[STR_VBAT] = {cur_vbat, 4'b0000};
    words[STR_TEMP] = {cur_temp, 8'h00};
    words[STR_GAIN] = {cur_gain, 8'h00};
    two_slot = {1'b0, 1'b0, vbat_wide, 1'b1, 1'b1, 1'b1};
  end

  // transmit edge selects which view of the position is current (R7)
  assign tx_evt = tx_on_fall ? fall_evt : rise_evt;
  assign tx_pos = tx_on_fall ? pos_q : pos_d;
  assign tx_len = tx_on_fall ? len_q : len_d;

  tdm_mstx_slotmap #(.POS_W(POS_W)) u_map (
    .bit_pos(tx_pos), .offset(tx_offset), .en(stream_en), .slot_idx(slot_idx),
    .words(words), .two_slot(two_slot), .frame_len(tx_len),
    .owned(map_owned), .bit_val(map_bit), .past_end(map_past_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sd_out <= 1'b0;
      sd_oe  <= 1'b0;
    end else if (tx_evt) begin
      sd_out <= map_owned & map_bit;
      sd_oe  <= map_owned | ~fill_hiz;
    end
  end

  assert_released_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_oe |-> !sd_out);

  assert_hold_between_edges_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_evt |=> $stable({sd_out, sd_oe}));

  assert_zero_fill_drives_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_evt && !fill_hiz) |=> sd_oe);

  assert_no_tx_past_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_evt && map_past_end && fill_hiz) |=> !sd_oe);
endmodule

// File: tb/tdm_mstream_tx_bench.sv
module tdm_mstream_tx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int H = 3;          // clk cycles per bit-clock phase
  localparam int MAXB = 1024;

  logic clk = 1'b0;
  logic rst_n, bclk, fsync, frame_pol, tx_on_fall, fill_hiz, vbat_wide;
  logic [2:0]  tx_offset;
  logic [5:0]  stream_en;
  logic [5:0]  slot [6];
  logic [35:0] slot_idx;
  logic [15:0] vsns_in, isns_in, pdm_in;
  logic [11:0] vbat_in;
  logic [7:0]  temp_in, gain_in;
  logic sd_out, sd_oe;

  int errors = 0, checks = 0, prev_len = 0;
  bit done = 0;
  bit exp_own [MAXB];
  bit exp_bit [MAXB];
  int exp_src [MAXB];

  assign slot_idx = {slot[5], slot[4], slot[3], slot[2], slot[1], slot[0]};

  always #(CLK_PERIOD/2) clk = ~clk;

  tdm_mstream_tx u_tdm_mstream_tx (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync), .frame_pol(frame_pol),
    .tx_on_fall(tx_on_fall), .tx_offset(tx_offset), .fill_hiz(fill_hiz),
    .stream_en(stream_en), .slot_idx(slot_idx), .vbat_wide(vbat_wide),
    .vsns_in(vsns_in), .isns_in(isns_in), .pdm_in(pdm_in), .vbat_in(vbat_in),
    .temp_in(temp_in), .gain_in(gain_in), .sd_out(sd_out), .sd_oe(sd_oe)
  );

  function automatic logic start_lvl();
    return frame_pol ? 1'b0 : 1'b1;  // R12
  endfunction

  task automatic check(string req, logic go, logic gd, logic eo, logic ed);
    checks++;
    if (go !== eo || gd !== ed) begin
      errors++;
      $display("FAIL %s: actual oe=%b out=%b expected oe=%b out=%b", req, go, gd, eo, ed);
    end
  endtask

  // Expected frame image: paint lowest priority first so winners overwrite (R10).
  task automatic build_model(int boundary);
    logic [15:0] w [6];
    w[0] = vsns_in; w[1] = isns_in; w[2] = pdm_in;
    w[3] = {vbat_in, 4'b0}; w[4] = {temp_in, 8'h00}; w[5] = {gain_in, 8'h00};
    for (int p = 0; p < MAXB; p++) begin exp_own[p] = 0; exp_bit[p] = 0; exp_src[p] = -1; end
    for (int s = 5; s >= 0; s--) begin
      int nb;
      if (!stream_en[s]) continue;               // R5
      nb = (s < 3) ? 2 : ((s == 3 && vbat_wide) ? 2 : 1);
      for (int b = 0; b < nb*8; b++) begin
        int p = int'(tx_offset) + int'(slot[s])*8 + b;   // R1, R6
        if (p < MAXB) begin exp_own[p] = 1; exp_bit[p] = w[s][15-b]; exp_src[p] = s; end
      end
    end
    for (int p = boundary; p < MAXB; p++) begin exp_own[p] = 0; exp_src[p] = -1; end  // R9
  endtask

  function automatic string tag_of(int p);
    if (exp_src[p] >= 0 && exp_src[p] < 3) return "R2";
    if (exp_src[p] == 3) return "R3";
    if (exp_src[p] > 3) return "R4";
    if (p >= prev_len) return "R9";
    return "R8";
  endfunction

  task automatic check_bit(string req, int p);
    logic eo, ed;
    eo = exp_own[p] ? 1'b1 : ~fill_hiz;
    ed = exp_own[p] ? exp_bit[p] : 1'b0;
    check(req, sd_oe, sd_out, eo, ed);
  endtask

  task automatic preroll(int n);
    for (int j = 0; j < n; j++) begin
      bclk = 1'b1;
      repeat (H) @(negedge clk);
      bclk = 1'b0;
      fsync = (j == n-1) ? start_lvl() : ~start_lvl();
      repeat (H) @(negedge clk);
    end
  endtask

  task automatic run_frame(int len);
    for (int k = 0; k < len; k++) begin
      bclk = 1'b1;
      if (k == 0) build_model(prev_len);     // samples captured here (R11)
      repeat (2) @(negedge clk);
      if (k > 0) check_bit("R7", tx_on_fall ? k-1 : k);   // R7 edge placement
      @(negedge clk);
      bclk = 1'b0;
      fsync = ((k+1 == len) || (k+1 < len/2)) ? start_lvl() : ~start_lvl();
      if (k == len/3) begin                  // R11: mid-frame change ignored
        vsns_in = ~vsns_in; isns_in = ~isns_in; pdm_in = ~pdm_in;
        vbat_in = ~vbat_in; temp_in = ~temp_in; gain_in = ~gain_in;
      end
      repeat (H) @(negedge clk);
      check_bit(tag_of(k), k);
    end
    prev_len = len;
  endtask

  task automatic rand_samples();
    vsns_in = 16'($urandom); isns_in = 16'($urandom); pdm_in = 16'($urandom);
    vbat_in = 12'($urandom); temp_in = 8'($urandom); gain_in = 8'($urandom);
  endtask

  task automatic rand_config();
    tx_on_fall = 1'($urandom); tx_offset = 3'($urandom); fill_hiz = 1'($urandom);
    vbat_wide = 1'($urandom); stream_en = 6'($urandom);
    for (int s = 0; s < 6; s++) slot[s] = 6'($urandom_range(0, 40));
  endtask

  function automatic int rand_len();
    int opts [5] = '{64, 96, 128, 192, 256};
    return opts[$urandom_range(0, 4)];
  endfunction

  task automatic do_reset(logic pol);
    rst_n = 1'b0; bclk = 1'b0; frame_pol = pol; fsync = ~start_lvl(); prev_len = 0;
    repeat (4) @(negedge clk);
    check("R8 reset", sd_oe, sd_out, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(7));
    tx_on_fall = 1; tx_offset = 3'd1; fill_hiz = 1; vbat_wide = 0; stream_en = 6'h3F;
    slot[0] = 0; slot[1] = 2; slot[2] = 4; slot[3] = 6; slot[4] = 7; slot[5] = 8;
    rand_samples();
    do_reset(1'b1);                          // R12 falling-sync start
    preroll(5);
    run_frame(64);                           // R9: no boundary known yet
    rand_samples(); run_frame(64);           // R9: temp/gain cut at bit 64
    tx_on_fall = 0; tx_offset = 0; fill_hiz = 0; vbat_wide = 1;   // R3 wide, R10 vbat over temp
    rand_samples(); run_frame(96);
    stream_en = 6'b100011; slot[0] = 3; slot[1] = 4; slot[5] = 4;  // R10 overlaps
    tx_on_fall = 1; tx_offset = 7; fill_hiz = 1;
    rand_samples(); run_frame(128);
    for (int f = 0; f < 6; f++) begin rand_config(); rand_samples(); run_frame(rand_len()); end
    do_reset(1'b0);                          // R12 rising-sync start
    preroll(4);
    for (int f = 0; f < 6; f++) begin rand_config(); rand_samples(); run_frame(rand_len()); end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R9 watchdog: actual=not finished expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule